// File: doc/BRIEF.md
# AXI ID-Filtered Traffic Event Generator

This block sits beside one AXI port of a memory controller and watches three handshakes: read address, write address and read data. For each handshake whose ID passes a programmable filter, it raises a one-cycle event pulse. There are three pulses: filtered read transactions, filtered write transactions and filtered read data beats. The counter bank takes these pulses as counter-specific event inputs. The block does not count anything itself.

The filter has two parts: a match value and a mask, both 18 bits wide. An ID bit matters only where the mask holds a 1, and in those positions it must equal the match value. Each of the three pulses has its own enable bit.

Software reaches the ID, the mask and the enables through a small register port. Writes to this port are synchronous. Reads are combinational.

Top module: `axi_id_evt_gen`

## Requirements
- R1: After reset, both configuration registers read as zero and all three event outputs are low.
- R2: The control register is at address 0x00. It holds:
  - the read-transaction enable at bit 31;
  - the write-transaction enable at bit 30;
  - the read-beat enable at bit 29;
  - the filter mask in bits 17:0.

  The match register is at address 0x04 and holds the match value in bits 17:0. All other bits read as zero. A write to any other address changes neither register.
- R3: An ID passes the filter when every bit position that has a 1 in the mask holds the same value in the ID as in the match value. Positions with a 0 in the mask are ignored.
- R4: A read-address handshake (valid and ready both high) with a passing ID and the read-transaction enable set produces a high `evt_rd_txn` for exactly the next cycle.
- R5: A write-address handshake with a passing ID and the write-transaction enable set produces a high `evt_wr_txn` for exactly the next cycle.
- R6: Every read-data handshake with a passing ID and the read-beat enable set produces a high `evt_rd_beat` in the next cycle. Beats in back-to-back cycles produce pulses in back-to-back cycles.
- R7: A valid that is not accepted by ready produces no event on that channel.
- R8: While an enable bit is clear, its event output stays low, whatever traffic occurs.
- R9: With a mask of zero, every ID passes.
- R10: A handshake in the same cycle as a configuration write is judged against the old configuration. The new value applies from the following cycle.
- R11: The three channels are judged independently. Handshakes on all of them in one cycle give pulses on all of them in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | 18 | Read-address ID |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | 18 | Write-address ID |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_id | input | 18 | Read-data ID |
| evt_rd_txn | output | 1 | Filtered read-transaction pulse |
| evt_wr_txn | output | 1 | Filtered write-transaction pulse |
| evt_rd_beat | output | 1 | Filtered read-beat pulse |

## Verification
Every pulse comes from one register stage. A wrong mask, match value or enable bit therefore shows as a missing or extra pulse in the cycle right after the first handshake that it misjudges. A misplaced field shows at once on `cfg_rdata`. The scoreboard predicts every output vector for the cycle after its stimulus and compares it in that cycle. Any stuck bit, swapped channel or wrong-cycle update is reported within one cycle of the stimulus that exposes it.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  // Register data width. The enable bit positions below assume 32.
  localparam int CFG_DW = 32;

  // Event channel indices, shared by the matchers, pulses and checker
  localparam int CH_RD   = 0;
  localparam int CH_WR   = 1;
  localparam int CH_BEAT = 2;
  localparam int N_CH    = 3;

  // Enable bit positions in the control register
  localparam int BIT_EN_RD   = 31;
  localparam int BIT_EN_WR   = 30;
  localparam int BIT_EN_BEAT = 29;

  // Register byte offsets
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MATCH = 8'h04;

  // Masked ID comparison: only bits with a 1 in the mask are compared
  function automatic logic id_pass(input logic [31:0] id,
                                   input logic [31:0] match,
                                   input logic [31:0] mask);
    return ((id ^ match) & mask) == 32'd0;
  endfunction
endpackage

// File: rtl/afilt_regs.sv
module afilt_regs
  import afilt_pkg::*;
#(
  parameter int ID_W = 18,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output logic [N_CH-1:0]   en,
  output logic [ID_W-1:0]   match,
  output logic [ID_W-1:0]   mask
);
  logic sel_ctrl, sel_match;
  logic unused_wbits;

  assign sel_ctrl  = (addr == AW'(OFS_CTRL));
  assign sel_match = (addr == AW'(OFS_MATCH));
  assign unused_wbits = ^wdata[BIT_EN_BEAT-1:ID_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      mask  <= '0;
      match <= '0;
    end else if (wr) begin
      if (sel_ctrl) begin
        en[CH_RD]   <= wdata[BIT_EN_RD];
        en[CH_WR]   <= wdata[BIT_EN_WR];
        en[CH_BEAT] <= wdata[BIT_EN_BEAT];
        mask        <= wdata[ID_W-1:0];
      end
      if (sel_match) begin
        match <= wdata[ID_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[BIT_EN_RD]   = en[CH_RD];
      rdata[BIT_EN_WR]   = en[CH_WR];
      rdata[BIT_EN_BEAT] = en[CH_BEAT];
      rdata[ID_W-1:0]    = mask;
    end else if (sel_match) begin
      rdata[ID_W-1:0] = match;
    end
  end
endmodule

// File: rtl/afilt_match.sv
module afilt_match
  import afilt_pkg::*;
#(
  parameter int ID_W = 18
) (
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] match,
  input  logic [ID_W-1:0] mask,
  input  logic            en,
  output logic            hs,
  output logic            hit,
  output logic            fire
);
  assign hs   = valid && ready;
  assign hit  = id_pass(32'(id), 32'(match), 32'(mask));
  assign fire = hs && hit && en;
endmodule

// File: rtl/afilt_pulse.sv
module afilt_pulse #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] evt
);
  // One register per channel gives a single-cycle pulse after each handshake
  for (genvar c = 0; c < N; c++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt[c] <= 1'b0;
      else        evt[c] <= fire[c];
    end
  end
endmodule

// File: rtl/axi_id_evt_gen.sv
module axi_id_evt_gen
  import afilt_pkg::*;
#(
  parameter int ID_W = 18,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              evt_rd_txn,
  output logic              evt_wr_txn,
  output logic              evt_rd_beat
);
  // Named internal events, one bit per channel, visible to the checker
  logic [N_CH-1:0] en, hs, hit, fire, evt;
  logic [N_CH-1:0] ch_valid, ch_ready;
  logic [ID_W-1:0] ch_id [N_CH];
  logic [ID_W-1:0] match, mask;

  assign ch_valid[CH_RD]   = ar_valid;
  assign ch_ready[CH_RD]   = ar_ready;
  assign ch_id[CH_RD]      = ar_id;
  assign ch_valid[CH_WR]   = aw_valid;
  assign ch_ready[CH_WR]   = aw_ready;
  assign ch_id[CH_WR]      = aw_id;
  assign ch_valid[CH_BEAT] = r_valid;
  assign ch_ready[CH_BEAT] = r_ready;
  assign ch_id[CH_BEAT]    = r_id;

  afilt_regs #(.ID_W(ID_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .en(en), .match(match), .mask(mask)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    afilt_match #(.ID_W(ID_W)) u_match (
      .valid(ch_valid[c]), .ready(ch_ready[c]), .id(ch_id[c]),
      .match(match), .mask(mask), .en(en[c]),
      .hs(hs[c]), .hit(hit[c]), .fire(fire[c])
    );
  end

  afilt_pulse #(.N(N_CH)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .evt(evt)
  );

  assign evt_rd_txn  = evt[CH_RD];
  assign evt_wr_txn  = evt[CH_WR];
  assign evt_rd_beat = evt[CH_BEAT];
endmodule

// File: rtl/axi_id_evt_gen_chk.sv
module axi_id_evt_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hs,
  input logic [2:0] hit,
  input logic [2:0] en,
  input logic [2:0] evt
);
  AST_RD_FIRE:   assert property (@(posedge clk) disable iff (!rst_n)
    (hs[0] && hit[0] && en[0]) |=> evt[0]);                      // R4
  AST_WR_FIRE:   assert property (@(posedge clk) disable iff (!rst_n)
    (hs[1] && hit[1] && en[1]) |=> evt[1]);                      // R5
  AST_BEAT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs[2] && hit[2] && en[2]) |=> evt[2]);                      // R6
  AST_NO_HS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == 3'b000) |=> (evt == 3'b000));                         // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 3'b000) |=> (evt == 3'b000));                         // R8
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == 3'b000) |=> (evt == 3'b000));                        // R3
  AST_EVT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt[0]) |-> $past(hs[0]));                             // R4
endmodule

bind axi_id_evt_gen axi_id_evt_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs(hs), .hit(hit), .en(en),
  .evt({evt_rd_beat, evt_wr_txn, evt_rd_txn})
);

// File: tb/tb_axi_id_evt_gen.sv
`timescale 1ns/1ps
module tb_axi_id_evt_gen;
  localparam int ID_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
  logic r_valid = 0, r_ready = 0;
  logic [ID_W-1:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic evt_rd_txn, evt_wr_txn, evt_rd_beat;

  always #10 clk = ~clk;

  axi_id_evt_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .evt_rd_txn(evt_rd_txn), .evt_wr_txn(evt_wr_txn), .evt_rd_beat(evt_rd_beat)
  );

  int total = 0;
  int bad = 0;

  // Stimulus staged for the next tick
  logic n_arv, n_arr, n_awv, n_awr, n_rv, n_rr, n_wr;
  logic [ID_W-1:0] n_arid, n_awid, n_rid;
  logic [7:0] n_addr;
  logic [31:0] n_data;

  // Bench's own model of the configuration
  logic [2:0] m_en;
  logic [ID_W-1:0] m_mask, m_match;

  // Scoreboard: expected {beat, wr, rd} and the requirement tag
  logic [2:0] exp_q[$];
  string tag_q[$];

  function automatic logic passes(input logic [ID_W-1:0] id);
    for (int i = 0; i < ID_W; i++)
      if (m_mask[i] && (id[i] != m_match[i])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic idle_stage();
    n_arv = 0; n_arr = 0; n_awv = 0; n_awr = 0; n_rv = 0; n_rr = 0; n_wr = 0;
    n_arid = '0; n_awid = '0; n_rid = '0; n_addr = 8'h00; n_data = '0;
  endtask

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Monitor: compare outputs against the oldest expected item
  task automatic monitor();
    logic [2:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({29'd0, evt_rd_beat, evt_wr_txn, evt_rd_txn}, {29'd0, e}, t);
    end
  endtask

  // Driver: apply the staged stimulus, predict the next-cycle outputs, update the model
  task automatic tick(input string tag);
    logic [2:0] e;
    @(negedge clk);
    monitor();
    ar_valid = n_arv; ar_ready = n_arr; ar_id = n_arid;
    aw_valid = n_awv; aw_ready = n_awr; aw_id = n_awid;
    r_valid = n_rv; r_ready = n_rr; r_id = n_rid;
    cfg_wr = n_wr; cfg_addr = n_addr; cfg_wdata = n_data;
    e[0] = n_arv && n_arr && m_en[0] && passes(n_arid);
    e[1] = n_awv && n_awr && m_en[1] && passes(n_awid);
    e[2] = n_rv && n_rr && m_en[2] && passes(n_rid);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (n_wr && n_addr == 8'h00) begin
      m_en = {n_data[29], n_data[30], n_data[31]};
      m_mask = n_data[ID_W-1:0];
    end else if (n_wr && n_addr == 8'h04) begin
      m_match = n_data[ID_W-1:0];
    end
    idle_stage();
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input string tag);
    n_wr = 1; n_addr = a; n_data = d;
    tick(tag);
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    n_addr = a;
    tick(tag);
    #2;
    check(cfg_rdata, exp, tag);
  endtask

  task automatic ar(input logic [ID_W-1:0] id, input logic rdy, input string tag);
    n_arv = 1; n_arr = rdy; n_arid = id; tick(tag);
  endtask
  task automatic aw(input logic [ID_W-1:0] id, input logic rdy, input string tag);
    n_awv = 1; n_awr = rdy; n_awid = id; tick(tag);
  endtask
  task automatic rb(input logic [ID_W-1:0] id, input logic rdy, input string tag);
    n_rv = 1; n_rr = rdy; n_rid = id; tick(tag);
  endtask

  bit done = 0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_stage();
    m_en = '0; m_mask = '0; m_match = '0;
    repeat (3) @(posedge clk);
    // R1: reset state
    #1;
    check({29'd0, evt_rd_beat, evt_wr_txn, evt_rd_txn}, 32'd0, "R1 events in reset");
    cfg_addr = 8'h00; #1; check(cfg_rdata, 32'd0, "R1 ctrl in reset");
    cfg_addr = 8'h04; #1; check(cfg_rdata, 32'd0, "R1 match in reset");
    @(negedge clk); rst_n = 1'b1;

    // R2: field layout, reserved bits and stray addresses
    cfg_write(8'h00, 32'hFFFF_FFFF, "R2 wr ctrl");
    reg_read(8'h00, 32'hE003_FFFF, "R2 ctrl readback");
    cfg_write(8'h04, 32'hFFFF_FFFF, "R2 wr match");
    reg_read(8'h04, 32'h0003_FFFF, "R2 match readback");
    cfg_write(8'h08, 32'h0000_0000, "R2 stray write");
    reg_read(8'h00, 32'hE003_FFFF, "R2 ctrl after stray");
    reg_read(8'h04, 32'h0003_FFFF, "R2 match after stray");

    // Full mask, exact match on 0x000A5
    cfg_write(8'h00, 32'hE003_FFFF, "R2 full mask all on");
    cfg_write(8'h04, 32'h0000_00A5, "R2 match 0xA5");
    ar(18'h000A5, 1, "R4 read txn hit");
    ar(18'h000A4, 1, "R3 read txn miss");
    aw(18'h000A5, 1, "R5 write txn hit");
    aw(18'h100A5, 1, "R3 write txn miss high bit");
    rb(18'h000A5, 1, "R6 beat 1");
    rb(18'h000A5, 1, "R6 beat 2");
    rb(18'h00000, 1, "R3 beat miss");
    rb(18'h000A5, 1, "R6 beat 3");
    tick("R6 idle after beats");

    // R7: valid without ready
    ar(18'h000A5, 0, "R7 ar stalled");
    aw(18'h000A5, 0, "R7 aw stalled");
    rb(18'h000A5, 0, "R7 r stalled");

    // R11: all three channels in one cycle
    n_arv = 1; n_arr = 1; n_arid = 18'h000A5;
    n_awv = 1; n_awr = 1; n_awid = 18'h000A5;
    n_rv = 1; n_rr = 1; n_rid = 18'h000A5;
    tick("R11 all channels");

    // R3: partial mask, low nibble must equal 5
    cfg_write(8'h00, 32'hE000_000F, "R3 nibble mask");
    cfg_write(8'h04, 32'h0000_0005, "R3 match 5");
    ar(18'h3FFF5, 1, "R3 upper bits ignored");
    ar(18'h00004, 1, "R3 masked bit differs");
    rb(18'h12345, 1, "R3 beat partial hit");

    // R9: zero mask passes all IDs
    cfg_write(8'h00, 32'hE000_0000, "R9 zero mask");
    ar(18'h2AAAA, 1, "R9 any id read");
    aw(18'h15555, 1, "R9 any id write");

    // R8: only the beat enable is set
    cfg_write(8'h00, 32'h2000_0000, "R8 beat only");
    ar(18'h00001, 1, "R8 read disabled");
    aw(18'h00001, 1, "R8 write disabled");
    rb(18'h00001, 1, "R8 beat enabled");

    // R10: a handshake in the write cycle uses the old enables
    n_wr = 1; n_addr = 8'h00; n_data = 32'h8000_0000;
    n_arv = 1; n_arr = 1; n_arid = 18'h00007;
    tick("R10 same-cycle write old cfg");
    ar(18'h00007, 1, "R10 next cycle new cfg");
    rb(18'h00007, 1, "R8 beat now disabled");
    tick("R10 drain");
    tick("R10 drain 2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule